// File: doc/BRIEF.md
# Interrupt Request Prioritizer and Vectoring

This block sits beside the instruction sequencer of a small 16-bit core with an 8-bit bus. It gathers every interrupt source into one decision at instruction boundaries:

- the maskable external request and the non-maskable request;
- the exception events raised by the instruction just retired (divide error, unused opcode, escape opcode, breakpoint, overflow trap, explicit software interrupt);
- the single-step trap.

The block picks the winner by fixed priority. It then issues a one-cycle take strobe together with the 8-bit interrupt type number that the sequencer uses to index the vector table.

The sequencer samples the block's flag outputs to update its flag register. These outputs pass the current interrupt-enable and trap bits through, except in the take cycle, where both are forced to zero. The handler therefore starts masked and is not single-stepped. A rising edge on the non-maskable input is captured and held until it is serviced, so a short pulse between boundaries is not lost. The external request is a level that counts only while interrupt-enable is set. The type for the external request is the byte presented on `ack_vec_i`, which the acknowledge cycle supplies.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset `take_o` is 0 and `type_o` is 0x00, and no non-maskable request is pending.
- R2: Sources are evaluated only on a clock edge where `boundary_i` is 1. `take_o` is 1 for the cycle after that edge and carries `type_o` then. With `boundary_i` at 0, no request causes a take.
- R3: Exception events give fixed type codes: divide error 0x00, unused opcode 0x06, escape opcode 0x07, breakpoint 0x03.
- R4: The overflow-trap event gives type 0x04 only when `ovf_flag_i` is 1. When it is 0, the event is ignored.
- R5: A software interrupt gives the type on `swint_type_i`, with any value 0x00 to 0xFF allowed.
- R6: A rising edge of `nmi_i` is latched and held pending until taken. It gives type 0x02 regardless of `if_i`. Holding `nmi_i` high does not raise a second request.
- R7: The external request `intr_i` is taken only while `if_i` is 1. Its type is `ack_vec_i`.
- R8: With `tf_i` at 1 at a boundary and no other source, the single-step trap gives type 0x01.
- R9: Priority, highest first: divide error, unused opcode, escape, breakpoint, overflow trap, software interrupt, non-maskable, external, single-step. A losing non-maskable request stays pending.
- R10: In the take cycle `if_o` and `tf_o` are 0. In every other cycle they equal `if_i` and `tf_i`.
- R11: A boundary that falls in the take cycle is ignored, so two takes are never back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | Instruction boundary; sources are evaluated on this edge |
| if_i | input | 1 | Current interrupt-enable flag |
| tf_i | input | 1 | Current trap (single-step) flag |
| ovf_flag_i | input | 1 | Current overflow flag |
| div_err_i | input | 1 | Divide error from retired instruction |
| bad_op_i | input | 1 | Unused opcode from retired instruction |
| esc_op_i | input | 1 | Escape opcode from retired instruction |
| brk_i | input | 1 | Breakpoint instruction retired |
| into_i | input | 1 | Overflow-trap instruction retired |
| swint_i | input | 1 | Software interrupt instruction retired |
| swint_type_i | input | 8 | Type operand of the software interrupt |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| intr_i | input | 1 | Maskable external request, level |
| ack_vec_i | input | 8 | Type byte from the acknowledge cycle |
| take_o | output | 1 | One-cycle interrupt entry strobe |
| type_o | output | 8 | Interrupt type number, valid with take_o |
| if_o | output | 1 | Next interrupt-enable value |
| tf_o | output | 1 | Next trap flag value |

## Verification
`take_o` and `type_o` appear one cycle after the rising edge on which `boundary_i` was sampled. `if_o` and `tf_o` follow `take_o` within that same cycle, with no extra delay. Every bench step drives its inputs just after a falling edge and queues the expected result after the next rising edge. The monitor then compares that entry at the falling edge that follows, so each result is read half a period after it settles. A latched non-maskable edge needs one cycle before a boundary can see it, and the bench leaves that gap. Every cycle, idle ones included, has its own queued expectation, so a missing strobe and an extra strobe are both caught.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int TYPE_W = 8;

  // index order is priority order, lowest index wins
  typedef enum int unsigned {
    SRC_DIV   = 0,
    SRC_UNDEF = 1,
    SRC_ESC   = 2,
    SRC_BRK   = 3,
    SRC_OVF   = 4,
    SRC_SWI   = 5,
    SRC_NMI   = 6,
    SRC_INTR  = 7,
    SRC_STEP  = 8,
    SRC_COUNT = 9
  } src_e;

  localparam int NSRC = int'(SRC_COUNT);

  function automatic logic [TYPE_W-1:0] fixed_type(input int idx);
    case (idx)
      int'(SRC_DIV):   return TYPE_W'(0);
      int'(SRC_UNDEF): return TYPE_W'(6);
      int'(SRC_ESC):   return TYPE_W'(7);
      int'(SRC_BRK):   return TYPE_W'(3);
      int'(SRC_OVF):   return TYPE_W'(4);
      int'(SRC_NMI):   return TYPE_W'(2);
      int'(SRC_STEP):  return TYPE_W'(1);
      default:         return TYPE_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic clr_i,
  output logic pend_o
);
  logic nmi_q;
  logic edge_det;

  assign edge_det = nmi_i & ~nmi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      nmi_q  <= nmi_i;
      // a fresh edge wins over a same-cycle clear
      pend_o <= (pend_o & ~clr_i) | edge_det;
    end
  end
endmodule

// File: rtl/irq_resolve.sv
module irq_resolve #(
  parameter  int NSRC   = 9,
  parameter  int TYPE_W = 8,
  localparam int IDX_W  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]             req_i,
  input  logic [NSRC-1:0][TYPE_W-1:0] type_i,
  output logic                        any_o,
  output logic [IDX_W-1:0]            idx_o,
  output logic [TYPE_W-1:0]           type_o
);
  always_comb begin
    any_o  = |req_i;
    idx_o  = '0;
    type_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o  = IDX_W'(i);
        type_o = type_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_take_reg.sv
module irq_take_reg #(
  parameter int TYPE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [TYPE_W-1:0] type_i,
  output logic              take_o,
  output logic [TYPE_W-1:0] type_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o <= 1'b0;
      type_o <= '0;
    end else begin
      take_o <= fire_i;
      if (fire_i) type_o <= type_i;
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boundary_i,
  input  logic              if_i,
  input  logic              tf_i,
  input  logic              ovf_flag_i,
  input  logic              div_err_i,
  input  logic              bad_op_i,
  input  logic              esc_op_i,
  input  logic              brk_i,
  input  logic              into_i,
  input  logic              swint_i,
  input  logic [TYPE_W-1:0] swint_type_i,
  input  logic              nmi_i,
  input  logic              intr_i,
  input  logic [TYPE_W-1:0] ack_vec_i,
  output logic              take_o,
  output logic [TYPE_W-1:0] type_o,
  output logic              if_o,
  output logic              tf_o
);
  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0]             req;
  logic [NSRC-1:0][TYPE_W-1:0] src_type;
  logic                        any_req;
  logic [IDX_W-1:0]            win_idx;
  logic [TYPE_W-1:0]           win_type;
  logic                        fire;
  logic                        nmi_pend;
  logic                        nmi_clr;

  always_comb begin
    req                 = '0;
    req[int'(SRC_DIV)]   = div_err_i;
    req[int'(SRC_UNDEF)] = bad_op_i;
    req[int'(SRC_ESC)]   = esc_op_i;
    req[int'(SRC_BRK)]   = brk_i;
    req[int'(SRC_OVF)]   = into_i & ovf_flag_i;
    req[int'(SRC_SWI)]   = swint_i;
    req[int'(SRC_NMI)]   = nmi_pend;
    req[int'(SRC_INTR)]  = intr_i & if_i;
    req[int'(SRC_STEP)]  = tf_i;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_type
    if (g == int'(SRC_SWI)) begin : g_sw
      assign src_type[g] = swint_type_i;
    end else if (g == int'(SRC_INTR)) begin : g_ext
      assign src_type[g] = ack_vec_i;
    end else begin : g_fix
      assign src_type[g] = fixed_type(g);
    end
  end

  irq_resolve #(.NSRC(NSRC), .TYPE_W(TYPE_W)) u_resolve (
    .req_i  (req),
    .type_i (src_type),
    .any_o  (any_req),
    .idx_o  (win_idx),
    .type_o (win_type)
  );

  // boundary in the entry cycle is dropped
  assign fire    = boundary_i & ~take_o & any_req;
  assign nmi_clr = fire & (win_idx == IDX_W'(int'(SRC_NMI)));

  irq_nmi_latch u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nmi_i  (nmi_i),
    .clr_i  (nmi_clr),
    .pend_o (nmi_pend)
  );

  irq_take_reg #(.TYPE_W(TYPE_W)) u_take (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .type_i (win_type),
    .take_o (take_o),
    .type_o (type_o)
  );

  assign if_o = if_i & ~take_o;
  assign tf_o = tf_i & ~take_o;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       boundary_i,
  input logic       if_i,
  input logic       tf_i,
  input logic       ovf_flag_i,
  input logic       div_err_i,
  input logic       bad_op_i,
  input logic       esc_op_i,
  input logic       brk_i,
  input logic       into_i,
  input logic       swint_i,
  input logic       nmi_i,
  input logic       intr_i,
  input logic       nmi_pend,
  input logic       take_o,
  input logic [7:0] type_o,
  input logic       if_o,
  input logic       tf_o
);
  // R2
  take_after_bnd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(boundary_i));

  // R11
  single_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o);

  // R10
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (!if_o && !tf_o));

  // R3
  div_type_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && !take_o && div_err_i) |=> (take_o && type_o == 8'h00));

  // R7
  intr_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && !take_o && intr_i && !if_i && !tf_i && !nmi_pend &&
     !div_err_i && !bad_op_i && !esc_op_i && !brk_i &&
     !(into_i && ovf_flag_i) && !swint_i) |=> !take_o);

  // R6
  nmi_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nmi_i) |=> nmi_pend);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .boundary_i (boundary_i),
  .if_i       (if_i),
  .tf_i       (tf_i),
  .ovf_flag_i (ovf_flag_i),
  .div_err_i  (div_err_i),
  .bad_op_i   (bad_op_i),
  .esc_op_i   (esc_op_i),
  .brk_i      (brk_i),
  .into_i     (into_i),
  .swint_i    (swint_i),
  .nmi_i      (nmi_i),
  .intr_i     (intr_i),
  .nmi_pend   (nmi_pend),
  .take_o     (take_o),
  .type_o     (type_o),
  .if_o       (if_o),
  .tf_o       (tf_o)
);

// File: tb/irq_vector_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bnd = 1'b0, if_r = 1'b0, tf_r = 1'b0, ovf = 1'b0;
  logic       div = 1'b0, bad = 1'b0, esc = 1'b0, brk = 1'b0, into = 1'b0, swi = 1'b0;
  logic [7:0] swi_ty = 8'h00, ack_vec = 8'h00;
  logic       nmi = 1'b0, intr = 1'b0;
  logic       take;
  logic [7:0] ty;
  logic       if_out, tf_out;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic       take;
    logic [7:0] ty;
    logic       ifv;
    logic       tfv;
    string      tag;
  } exp_t;
  exp_t q[$];
  exp_t cur;

  always #2 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .boundary_i(bnd), .if_i(if_r), .tf_i(tf_r),
    .ovf_flag_i(ovf), .div_err_i(div), .bad_op_i(bad), .esc_op_i(esc),
    .brk_i(brk), .into_i(into), .swint_i(swi), .swint_type_i(swi_ty),
    .nmi_i(nmi), .intr_i(intr), .ack_vec_i(ack_vec),
    .take_o(take), .type_o(ty), .if_o(if_out), .tf_o(tf_out)
  );

  // monitor: compare one queued expectation per falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      cur = q.pop_front();
      checks++;
      if (take !== cur.take || (cur.take && ty !== cur.ty) ||
          if_out !== cur.ifv || tf_out !== cur.tfv) begin
        errors++;
        $display("FAIL %s: take=%0b type=%02h if=%0b tf=%0b expected take=%0b type=%02h if=%0b tf=%0b",
                 cur.tag, take, ty, if_out, tf_out, cur.take, cur.ty, cur.ifv, cur.tfv);
      end
    end
  end

  // driver: one cycle, queue the result due after the next rising edge
  task automatic step(input logic b, input logic etake, input logic [7:0] ety, input string tag);
    exp_t e;
    bnd = b;
    @(posedge clk);
    #1;
    e.take = etake;
    e.ty   = ety;
    e.ifv  = etake ? 1'b0 : if_r;
    e.tfv  = etake ? 1'b0 : tf_r;
    e.tag  = tag;
    q.push_back(e);
    @(negedge clk);
    #1;
    bnd = 1'b0;
    div = 1'b0; bad = 1'b0; esc = 1'b0; brk = 1'b0; into = 1'b0; swi = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (take !== 1'b0 || ty !== 8'h00) begin
      errors++;
      $display("FAIL R1 reset: take=%0b type=%02h expected take=0 type=00", take, ty);
    end
    rst_n = 1'b1;
    #1;

    step(0, 0, 8'h00, "R1 idle after reset");
    // R7 masked external request
    intr = 1'b1; ack_vec = 8'h41; if_r = 1'b0;
    step(1, 0, 8'h00, "R7 masked intr");
    if_r = 1'b1;
    step(1, 1, 8'h41, "R7 intr taken");
    step(0, 0, 8'h00, "R10 flags restored");
    step(0, 0, 8'h00, "R2 no boundary no take");
    intr = 1'b0;

    // R3 fixed exception types
    div = 1'b1; step(1, 1, 8'h00, "R3 divide error");  step(0, 0, 8'h00, "R3 idle");
    bad = 1'b1; step(1, 1, 8'h06, "R3 unused opcode"); step(0, 0, 8'h00, "R3 idle");
    esc = 1'b1; step(1, 1, 8'h07, "R3 escape");        step(0, 0, 8'h00, "R3 idle");
    brk = 1'b1; step(1, 1, 8'h03, "R3 breakpoint");    step(0, 0, 8'h00, "R3 idle");

    // R4 overflow trap
    ovf = 1'b0; into = 1'b1; step(1, 0, 8'h00, "R4 trap ignored with ovf clear");
    ovf = 1'b1; into = 1'b1; step(1, 1, 8'h04, "R4 overflow trap");
    step(0, 0, 8'h00, "R4 idle");

    // R5 software interrupt
    swi = 1'b1; swi_ty = 8'hFF; step(1, 1, 8'hFF, "R5 int ff"); step(0, 0, 8'h00, "R5 idle");
    swi = 1'b1; swi_ty = 8'h80; step(1, 1, 8'h80, "R5 int 80"); step(0, 0, 8'h00, "R5 idle");

    // R6 NMI latched, unmasked, edge only
    if_r = 1'b0; nmi = 1'b1;
    step(0, 0, 8'h00, "R6 latch cycle");
    step(1, 1, 8'h02, "R6 nmi with if clear");
    step(0, 0, 8'h00, "R6 idle");
    step(1, 0, 8'h00, "R6 held level no retrigger");
    nmi = 1'b0;
    step(0, 0, 8'h00, "R6 idle");

    // R8 single step
    tf_r = 1'b1;
    step(1, 1, 8'h01, "R8 single step");
    step(0, 0, 8'h00, "R10 tf passes through");

    // R9 pairs
    if_r = 1'b1; intr = 1'b1; ack_vec = 8'h20;
    step(1, 1, 8'h20, "R9 intr over step");
    nmi = 1'b1;
    step(0, 0, 8'h00, "R9 nmi latch");
    step(1, 1, 8'h02, "R9 nmi over intr");
    step(0, 0, 8'h00, "R9 idle");
    step(1, 1, 8'h20, "R9 intr after nmi");
    step(0, 0, 8'h00, "R9 idle");
    intr = 1'b0; nmi = 1'b0;
    step(0, 0, 8'h00, "R9 idle");
    nmi = 1'b1;
    step(0, 0, 8'h00, "R9 nmi latch");
    div = 1'b1;
    step(1, 1, 8'h00, "R9 divide over nmi");
    step(0, 0, 8'h00, "R9 idle");
    step(1, 1, 8'h02, "R9 nmi kept pending");
    step(0, 0, 8'h00, "R9 idle");
    nmi = 1'b0;
    tf_r = 1'b0;
    div = 1'b1; bad = 1'b1; step(1, 1, 8'h00, "R9 divide over unused"); step(0, 0, 8'h00, "R9 idle");
    bad = 1'b1; esc = 1'b1; step(1, 1, 8'h06, "R9 unused over escape"); step(0, 0, 8'h00, "R9 idle");
    brk = 1'b1; swi = 1'b1; swi_ty = 8'h55; step(1, 1, 8'h03, "R9 breakpoint over int n"); step(0, 0, 8'h00, "R9 idle");
    into = 1'b1; swi = 1'b1; step(1, 1, 8'h04, "R9 overflow over int n"); step(0, 0, 8'h00, "R9 idle");

    // R11 boundary during entry cycle
    intr = 1'b1; ack_vec = 8'h33;
    step(1, 1, 8'h33, "R11 first take");
    step(1, 0, 8'h00, "R11 boundary in take cycle ignored");
    step(1, 1, 8'h33, "R11 next boundary taken");
    intr = 1'b0;
    step(0, 0, 8'h00, "R11 idle");

    @(negedge clk);
    #1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule